// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor and a slower backing memory. It holds one block of several words per line and chooses the line from the middle bits of the request address. For each line it keeps a stored tag and a valid flag. A read that finds its block resident completes in the same cycle it is presented. A read that misses stalls the processor while the whole block is fetched word by word. The controller then records the new tag, marks the line valid and retries the access, and the retry now hits.

Every store is written through to memory. The cache line is updated at once, and the word is posted into a small first-in first-out write queue that drains to memory in the background. The processor is held only when that queue is full. A store to a block that is not resident first fetches the block and then merges the stored word into it. Before any block fetch starts, the queue is drained completely, so a fetch always sees every earlier store.

The number of lines, the words per block, the data and address widths and the queue depth are parameters. Lines, words per block and queue depth must be powers of two and at least 2. The processor must hold its request unchanged until `cpu_ready` is seen.

Top module: `wt_cache_ctrl`

## Requirements
- R1: With the default geometry the address splits into bits [1:0] (byte within word, ignored), bits [3:2] (word in block), bits [6:4] (line index) and bits [31:7] (tag). Two addresses with the same index and different tags displace each other, so the second one misses.
- R2: After reset every line is invalid, and the first access to any line is a miss.
- R3: On a read miss the controller raises `mem_rd_req` for exactly one cycle with a block-aligned `mem_rd_addr` (the low 4 bits are zero). Memory returns the block as WORDS beats on `mem_rd_valid`, word 0 first. The access completes with the requested word in the cycle after the last beat.
- R4: A read hit completes (`cpu_ready` high) in the cycle the request is first presented. It returns the word chosen by the word-in-block field and starts no memory read.
- R5: A write hit with a non-full queue completes in the cycle it is presented. Later reads return the new word. The word appears on the memory write port from the next cycle, and memory ends up holding every stored word.
- R6: A write miss fetches the block, merges the stored word into it and completes in the cycle after the last fill beat. The other words of that block keep their memory values.
- R7: Queued writes leave in store order. Each one is held stable on the write port until `mem_wr_ack` and is removed on that ack. With WQ_DEPTH entries queued, a store stalls until a slot frees.
- R8: `cpu_stall` is high exactly when a request is pending and not completing in that cycle. It is never high together with `cpu_ready`.
- R9: `mem_rd_req` is never raised while the write queue holds any entry.
- R10: While reset is held, `cpu_ready`, `cpu_stall`, `mem_rd_req` and `mem_wr_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request pending |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Request pending but held |
| mem_rd_req | output | 1 | One-cycle block fetch request |
| mem_rd_addr | output | ADDR_W | Block-aligned fetch address |
| mem_rd_valid | input | 1 | Fill beat valid |
| mem_rd_data | input | DATA_W | Fill beat data |
| mem_wr_req | output | 1 | Queued write waiting |
| mem_wr_addr | output | ADDR_W | Word-aligned write address |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_ack | input | 1 | Memory accepted the head write |

## Verification
A wrong valid flag or stored tag shows at the ports in one of two ways: a load that should miss completes in the cycle it is presented with stale data, or a load that should hit raises a fetch and stalls. The bench predicts residency and the queue depth on its own, so either error is caught on the very access concerned. A corrupted data word or a wrong word-in-block decode shows as a wrong `cpu_rdata` on the next load of that word. A queue that loses, reorders or holds a write too briefly shows as a mismatched address or data on the ack of that entry, or as a stale word returned after a later refill.

// File: rtl/wt_cache_pkg.sv
// Shared types for the write-through cache controller.
package wt_cache_pkg;

    // Refill sequencer states
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,   // serving hits
        FS_DRAIN = 2'd1,   // waiting for the write queue to empty
        FS_ASK   = 2'd2,   // issuing the block fetch
        FS_FILL  = 2'd3    // collecting fill beats
    } fill_state_t;

endpackage

// File: rtl/wt_line_store.sv
// Line storage: per-line valid flag, tag and WORDS data words.
// Assumes: LINES and WORDS are powers of two, at least 2. There is one
// asynchronous read port and one synchronous word write port. Tag and valid
// are set together by tag_set. Only the valid flags are reset.
module wt_line_store #(
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 25,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WOFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WOFF_W-1:0] rd_woff,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WOFF_W-1:0] wr_woff,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_set,
    input  logic [TAG_W-1:0]  tag_val
);

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES][WORDS];

    // One valid flag per line, cleared by reset and set when its tag is written
    for (genvar l = 0; l < LINES; l++) begin : g_valid
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[l] <= 1'b0;
            else if (tag_set && wr_idx == IDX_W'(l))
                valid_q[l] <= 1'b1;
        end
    end

    // Tag array write on line completion
    always_ff @(posedge clk) begin
        if (tag_set)
            tag_q[wr_idx] <= tag_val;
    end

    // Data word write (fill beat or store merge)
    always_ff @(posedge clk) begin
        if (wr_en)
            data_q[wr_idx][wr_woff] <= wr_data;
    end

    // Lookup of the addressed line and word
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_word  = data_q[rd_idx][rd_woff];
    end

endmodule

// File: rtl/wt_write_queue.sv
// Posted-write FIFO: holds word addresses and data until memory acks them.
// Assumes: push is only raised when not full, and pop only when not empty.
// Pushing and popping in the same cycle is allowed.
module wt_write_queue #(
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 4,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [WADDR_W-1:0] push_waddr,
    input  logic [DATA_W-1:0]  push_data,
    input  logic               pop,
    output logic [WADDR_W-1:0] head_waddr,
    output logic [DATA_W-1:0]  head_data,
    output logic               empty,
    output logic               full
);

    logic [WADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0]  data_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [PTR_W:0]     count;

    // Entry storage written at the tail
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_waddr;
            data_q[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        end
    end

    // Head presentation and flags
    always_comb begin
        head_waddr = addr_q[rd_ptr];
        head_data  = data_q[rd_ptr];
        empty      = (count == '0);
        full       = (count == (PTR_W+1)'(DEPTH));
    end

endmodule

// File: rtl/wt_fill_ctrl.sv
// Refill sequencer: on a miss it waits for the write queue to empty, issues
// a one-cycle block fetch, then counts WORDS fill beats in ascending order.
// Assumes: the memory returns exactly WORDS beats per fetch, and the miss
// address is held by the processor for the whole sequence.
module wt_fill_ctrl #(
    parameter int WORDS = 4,
    localparam int BEAT_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_start,
    input  logic              wq_empty,
    input  logic              mem_rd_valid,
    output logic              busy,
    output logic              fetch_req,
    output logic              fill_we,
    output logic              fill_last,
    output logic [BEAT_W-1:0] beat
);
    import wt_cache_pkg::*;

    fill_state_t state_q, state_d;
    logic [BEAT_W-1:0] beat_q;

    // Next-state selection for the miss sequence
    always_comb begin
        state_d = state_q;
        case (state_q)
            FS_IDLE:  if (miss_start) state_d = wq_empty ? FS_ASK : FS_DRAIN;
            FS_DRAIN: if (wq_empty)   state_d = FS_ASK;
            FS_ASK:   state_d = FS_FILL;
            FS_FILL:  if (fill_last)  state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    // State and beat counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FS_ASK)
                beat_q <= '0;
            else if (fill_we)
                beat_q <= beat_q + 1'b1;
        end
    end

    // Decoded controls
    always_comb begin
        busy      = (state_q != FS_IDLE);
        fetch_req = (state_q == FS_ASK);
        fill_we   = (state_q == FS_FILL) && mem_rd_valid;
        fill_last = fill_we && (beat_q == BEAT_W'(WORDS - 1));
        beat      = beat_q;
    end

endmodule

// File: rtl/wt_cache_ctrl.sv
// Direct-mapped write-through cache controller with a posted write queue.
// Hits complete combinationally. A miss drains the queue, fetches the block,
// sets tag and valid, and then retries the access. Stores update the line
// and are queued for memory. Assumes the processor holds its request
// stable until cpu_ready.
module wt_cache_ctrl #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LINES    = 8,
    parameter int WORDS    = 4,
    parameter int WQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_stall,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);

    localparam int BOFF_W  = $clog2(DATA_W / 8);
    localparam int WOFF_W  = $clog2(WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int IDX_LSB = BOFF_W + WOFF_W;
    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;
    localparam int WADDR_W = ADDR_W - BOFF_W;

    logic [WOFF_W-1:0]  a_woff;
    logic [IDX_W-1:0]   a_idx;
    logic [TAG_W-1:0]   a_tag;
    logic               unused_byte_bits;
    logic               line_valid, hit, busy;
    logic [TAG_W-1:0]   line_tag;
    logic               store_go, miss_start;
    logic               fetch_req, fill_we, fill_last;
    logic [WOFF_W-1:0]  beat;
    logic               wq_empty, wq_full;
    logic [WADDR_W-1:0] head_waddr;
    logic               st_we;
    logic [WOFF_W-1:0]  st_woff;
    logic [DATA_W-1:0]  st_wdata;

    // Address field split
    always_comb begin
        a_woff = cpu_addr[IDX_LSB-1:BOFF_W];
        a_idx  = cpu_addr[TAG_LSB-1:IDX_LSB];
        a_tag  = cpu_addr[ADDR_W-1:TAG_LSB];
    end
    assign unused_byte_bits = ^cpu_addr[BOFF_W-1:0];

    // Hit decision and processor handshake
    always_comb begin
        hit        = line_valid && (line_tag == a_tag);
        cpu_ready  = cpu_req && !busy && hit && (!cpu_we || !wq_full);
        cpu_stall  = cpu_req && !cpu_ready;
        store_go   = cpu_ready && cpu_we;
        miss_start = cpu_req && !busy && !hit;
    end

    // Storage write port: fill beats take the port, store merges otherwise
    always_comb begin
        st_we    = fill_we || store_go;
        st_woff  = fill_we ? beat : a_woff;
        st_wdata = fill_we ? mem_rd_data : cpu_wdata;
    end

    wt_line_store #(
        .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(a_idx), .rd_woff(a_woff),
        .rd_valid(line_valid), .rd_tag(line_tag), .rd_word(cpu_rdata),
        .wr_en(st_we), .wr_idx(a_idx), .wr_woff(st_woff), .wr_data(st_wdata),
        .tag_set(fill_last), .tag_val(a_tag)
    );

    wt_fill_ctrl #(.WORDS(WORDS)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .miss_start(miss_start), .wq_empty(wq_empty),
        .mem_rd_valid(mem_rd_valid),
        .busy(busy), .fetch_req(fetch_req), .fill_we(fill_we),
        .fill_last(fill_last), .beat(beat)
    );

    wt_write_queue #(
        .WADDR_W(WADDR_W), .DATA_W(DATA_W), .DEPTH(WQ_DEPTH)
    ) u_wq (
        .clk(clk), .rst_n(rst_n),
        .push(store_go), .push_waddr(cpu_addr[ADDR_W-1:BOFF_W]),
        .push_data(cpu_wdata),
        .pop(mem_wr_ack && !wq_empty),
        .head_waddr(head_waddr), .head_data(mem_wr_data),
        .empty(wq_empty), .full(wq_full)
    );

    // Memory-side outputs
    always_comb begin
        mem_rd_req  = fetch_req;
        mem_rd_addr = {cpu_addr[ADDR_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
        mem_wr_req  = !wq_empty;
        mem_wr_addr = {head_waddr, {BOFF_W{1'b0}}};
    end

endmodule

// File: rtl/wt_cache_chk.sv
// Protocol checker for wt_cache_ctrl, attached with bind below.
module wt_cache_chk #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int ALIGN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              cpu_stall,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_wr_req,
    input logic              mem_wr_ack,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data
);

    // R3
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R3
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[ALIGN_W-1:0] == '0));

    // R9
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !mem_wr_req);

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=>
            (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R5
    post_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |=> mem_wr_req);

    // R8
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (!cpu_ready && cpu_req));

    // R4
    ready_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_rd_req);

endmodule

bind wt_cache_ctrl wt_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_W(IDX_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
    .cpu_stall(cpu_stall),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/wt_cache_ctrl_tb.sv
// Bench: behavioural memory with fixed per-word latency, flat reference
// array, residency and queue-depth prediction, checked on every clock.
module wt_cache_ctrl_tb;

    localparam int AW = 32, DW = 32, LN = 8, WD = 4, QD = 4;
    localparam int MEMW = 256, RLAT = 3, WLAT = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ready, cpu_stall;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_valid = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic          mem_wr_req;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          mem_wr_ack = 1'b0;

    wt_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(LN), .WORDS(WD),
                    .WQ_DEPTH(QD)) u_dut (.*);

    int checks = 0, errors = 0, cyc = 0, last_beat = -10;
    int wq_pre = 0, wq_cnt = 0, full_stalls = 0;
    logic [DW-1:0] mem  [MEMW];
    logic [DW-1:0] refm [MEMW];
    logic [AW-1:0] exp_a [$];
    logic [DW-1:0] exp_d [$];
    bit tb_val [LN];
    int tb_tag [LN];

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model and per-clock monitor
    initial begin
        bit rbusy = 0, wact = 0;
        int rwait = 0, rbeat = 0, rbase = 0, wcnt = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
            mem_rd_valid = 1'b0;
            if (rbusy) begin
                if (rwait > 0) rwait--;
                else begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mem[rbase + rbeat];
                    rbeat++;
                    if (rbeat == WD) begin rbusy = 0; last_beat = cyc; end
                end
            end else if (rst_n && mem_rd_req) begin
                rbusy = 1; rwait = RLAT; rbeat = 0; rbase = int'(mem_rd_addr[9:2]);
            end
            if (mem_wr_ack) mem_wr_ack = 1'b0;
            else if (!wact && rst_n && mem_wr_req) begin wact = 1; wcnt = WLAT; end
            else if (wact) begin
                if (wcnt == 0) begin
                    // R7: order and content of drained writes
                    if (exp_a.size() == 0) chk(0, "R7 unexpected write", mem_wr_addr, 0);
                    else begin
                        chk(mem_wr_addr == exp_a[0], "R7 write order addr", mem_wr_addr, exp_a[0]);
                        chk(mem_wr_data == exp_d[0], "R7 write order data", mem_wr_data, exp_d[0]);
                        void'(exp_a.pop_front()); void'(exp_d.pop_front());
                    end
                    mem[mem_wr_addr[9:2]] = mem_wr_data;
                    mem_wr_ack = 1'b1;
                    wact = 0;
                end else wcnt--;
            end
            #2;
            if (rst_n) begin
                wq_pre = wq_cnt;
                wq_cnt = wq_cnt + int'(cpu_ready && cpu_we) - int'(mem_wr_req && mem_wr_ack);
                chk(cpu_stall == (cpu_req && !cpu_ready), "R8 stall", 32'(cpu_stall), 32'(cpu_req && !cpu_ready));
                if (mem_rd_req) begin
                    chk(wq_pre == 0, "R9 fetch with queued writes", wq_pre, 0);
                    chk(mem_rd_addr == {cpu_addr[31:4], 4'h0}, "R3 fetch address", mem_rd_addr, {cpu_addr[31:4], 4'h0});
                end
            end
        end
    end

    // One processor access, held until completion
    task automatic access(bit we, logic [31:0] a, logic [31:0] d, string tag);
        int w = int'(a[9:2]);
        int idx = int'(a[6:4]);
        int tg = int'(a[31:7]);
        bit hit_p = tb_val[idx] && tb_tag[idx] == tg;
        bit full_p;
        int waited = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #3;
        full_p = (wq_pre == QD);
        while (!cpu_ready && waited < 3000) begin
            @(negedge clk); #3; waited++;
        end
        if (!hit_p) begin
            chk(waited > 0, {tag, " miss must stall"}, waited, 1);
            chk(cyc == last_beat + 1, {tag, " completes after last beat"}, cyc, last_beat + 1);
        end else if (we && full_p) begin
            chk(waited > 0, "R7 full queue stalls store", waited, 1);
            full_stalls++;
        end else begin
            chk(waited == 0, {tag, " hit completes at once"}, waited, 0);
        end
        if (!we) chk(cpu_rdata == refm[w], {tag, " read data"}, cpu_rdata, refm[w]);
        else begin
            refm[w] = d;
            exp_a.push_back({a[31:2], 2'b00});
            exp_d.push_back(d);
        end
        tb_val[idx] = 1'b1;
        tb_tag[idx] = tg;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        cpu_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEMW; i++) begin
            mem[i]  = 32'h5A00_0000 + i * 32'h0001_0203;
            refm[i] = mem[i];
        end
        for (int i = 0; i < LN; i++) begin tb_val[i] = 0; tb_tag[i] = 0; end
        repeat (4) @(negedge clk);
        #3;
        // R10: quiet outputs under reset
        chk(!cpu_ready && !cpu_stall, "R10 cpu side in reset", {cpu_ready, cpu_stall}, 0);
        chk(!mem_rd_req && !mem_wr_req, "R10 memory side in reset", {mem_rd_req, mem_wr_req}, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        chk(!mem_rd_req && !mem_wr_req, "R10 quiet after reset", {mem_rd_req, mem_wr_req}, 0);

        // R2/R3: cold misses, then R4 hits on other offsets
        access(0, 32'h000, 0, "R2");
        access(0, 32'h004, 0, "R4");
        access(0, 32'h00C, 0, "R4");
        access(0, 32'h00B, 0, "R1");       // byte offset ignored: word 2
        access(0, 32'h010, 0, "R3");
        // R1: same index, different tag displaces
        access(0, 32'h088, 0, "R1");
        access(0, 32'h000, 0, "R1");
        // R5: write hit, then read back
        access(1, 32'h014, 32'hDEAD_0014, "R5");
        access(0, 32'h014, 0, "R5");
        // R6: write miss merges into fetched block
        access(1, 32'h104, 32'hBEEF_0104, "R6");
        access(0, 32'h100, 0, "R6");
        access(0, 32'h104, 0, "R6");
        access(0, 32'h108, 0, "R6");
        // R7: burst of stores fills the queue
        for (int k = 0; k < 10; k++)
            access(1, 32'h010 + 32'((k % 4) * 4), 32'hC0DE_0000 + 32'(k), "R7");
        // R9: read miss right after stores must wait for the drain
        access(0, 32'h290, 0, "R9");
        access(0, 32'h010, 0, "R9");
        idle(1);
        chk(full_stalls > 0, "R7 queue-full stall observed", full_stalls, 1);

        // Mixed traffic
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a = 32'($urandom_range(0, 1023));
            bit we = ($urandom_range(0, 9) < 4);
            access(we, a, $urandom, we ? "R5" : "R4");
        end
        idle(60);
        // R5: memory image after drain
        begin
            int bad = 0;
            for (int i = 0; i < MEMW; i++) if (mem[i] !== refm[i]) bad++;
            chk(bad == 0, "R5 memory image", bad, 0);
            chk(exp_a.size() == 0, "R7 queue drained", exp_a.size(), 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule